// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel RGB LCD panel. A pixel-clock counter sweeps each line, and a line counter advances once per line and sweeps each frame. From these two positions and ten programmed 12-bit values, five per axis, the block derives active-low horizontal and vertical sync, a data-enable strobe, and the x/y position of the current pixel inside the visible window.

Each axis takes five settings. The total is the whole line or frame length. The size is the visible span. The offset is the blank span before the visible window, which covers front porch, pulse and back porch. Two absolute counter positions bound the sync pulse: the pulse starts at the end of the front porch and ends at the end of the front porch plus pulse. Software drives the programmed values onto the setting inputs at any time. The block copies them into its working set only at a frame boundary, so no frame is drawn with mixed timing. An illegal working set stops the raster, and the block then picks up new settings on every cycle until a legal set arrives. The block has no streaming data path, so no valid/ready handshake applies. All pins are plain control and timing signals.

Top module: `lcd_timing_gen`

## Requirements
- R1: The horizontal counter runs 0..total-1 and wraps, so hsync_n falls once every h_total pixel clocks. The full 12-bit range up to 4095 is supported.
- R2: The line counter advances only on a horizontal wrap and itself wraps at v_total-1, so vsync_n falls once every h_total*v_total clocks.
- R3: hsync_n is low while the horizontal count c satisfies h_sync_a <= c < h_sync_b. If h_sync_a equals h_sync_b, no pulse is produced.
- R4: vsync_n is low while the line count l satisfies v_sync_a <= l < v_sync_b.
- R5: de is high only when offset <= count < offset+size holds on both axes. A size of zero keeps de low.
- R6: pix_x = count-h_offset and pix_y = line-v_offset while de is high. Both are 0 while de is low.
- R7: A change on the setting inputs takes effect only when both counters wrap to zero together.
- R8: A working set is illegal when total is 0 or offset+size >= total on either axis. While it is illegal, both counters are held at 0, de stays low and both syncs stay high. The next legal input set is taken at once.
- R9: During reset the outputs are hsync_n=1, vsync_n=1, de=0 and pix_x=pix_y=0.
- R10: Every output is registered and reflects the counter state one pixel clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_total_i | input | 12 | Line length in pixel clocks |
| h_size_i | input | 12 | Visible pixels per line |
| h_offset_i | input | 12 | Blank pixels before the visible window |
| h_sync_a_i | input | 12 | Horizontal count where the sync pulse starts |
| h_sync_b_i | input | 12 | Horizontal count where the sync pulse ends |
| v_total_i | input | 12 | Frame length in lines |
| v_size_i | input | 12 | Visible lines per frame |
| v_offset_i | input | 12 | Blank lines before the visible window |
| v_sync_a_i | input | 12 | Line where vertical sync starts |
| v_sync_b_i | input | 12 | Line where vertical sync ends |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable for visible pixels |
| pix_x | output | 12 | Column inside the visible window |
| pix_y | output | 12 | Row inside the visible window |

## Verification
A counter that wraps one value early or late changes the spacing of hsync_n falling edges, and the spacing of vsync_n edges for the line counter. This shows one clock after the bad count, within one line. A working set loaded at the wrong moment moves the sync and de edges inside the frame where it happens, while an illegal set that is not detected lets de or a sync pulse through within one line. A behavioural model of the raster in the bench predicts every output on every pixel clock, so any such fault becomes a miscompare on the first affected clock.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  localparam int TW = 12;
  localparam int NAXIS = 2;

  typedef logic [TW-1:0] tval_t;

  typedef struct packed {
    tval_t total;
    tval_t size;
    tval_t offset;
    tval_t sync_a;
    tval_t sync_b;
  } axis_cfg_t;

  // legal when the blank span plus the visible span fits strictly inside total
  function automatic logic axis_legal(axis_cfg_t c);
    logic [TW:0] span;
    span = {1'b0, c.offset} + {1'b0, c.size};
    return span < {1'b0, c.total};
  endfunction
endpackage

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         at_end
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  assign at_end = (cnt_q == total - ONE);
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= at_end ? '0 : cnt_q + ONE;
    end
  end

  // R1: with a legal set the count never reaches total
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt_q < total));

  // R2: a step at the last position lands on zero
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_end && !clr) |=> (cnt_q == '0));
endmodule

// File: rtl/lcd_axis_decode.sv
module lcd_axis_decode
  import lcd_timing_pkg::*;
(
  input  tval_t     cnt,
  input  axis_cfg_t cfg,
  output logic      sync_on,
  output logic      win_on,
  output tval_t     rel
);
  logic [TW:0] win_end;

  assign win_end = {1'b0, cfg.offset} + {1'b0, cfg.size};
  assign sync_on = (cnt >= cfg.sync_a) && (cnt < cfg.sync_b);
  assign win_on  = (cnt >= cfg.offset) && ({1'b0, cnt} < win_end);
  assign rel     = cnt - cfg.offset;
endmodule

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
  import lcd_timing_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  axis_cfg_t h_new,
  input  axis_cfg_t v_new,
  output axis_cfg_t h_act,
  output axis_cfg_t v_act,
  output logic      legal
);
  axis_cfg_t h_q, v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else if (load) begin
      h_q <= h_new;
      v_q <= v_new;
    end
  end

  assign h_act = h_q;
  assign v_act = v_q;
  assign legal = axis_legal(h_q) && axis_legal(v_q);

  // R7: the working set only moves on a load
  p_cfg_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(h_q) && $stable(v_q)));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] h_total_i,
  input  logic [TW-1:0] h_size_i,
  input  logic [TW-1:0] h_offset_i,
  input  logic [TW-1:0] h_sync_a_i,
  input  logic [TW-1:0] h_sync_b_i,
  input  logic [TW-1:0] v_total_i,
  input  logic [TW-1:0] v_size_i,
  input  logic [TW-1:0] v_offset_i,
  input  logic [TW-1:0] v_sync_a_i,
  input  logic [TW-1:0] v_sync_b_i,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic [TW-1:0] pix_x,
  output logic [TW-1:0] pix_y
);
  axis_cfg_t        h_new, v_new;
  axis_cfg_t        act [NAXIS];
  logic             legal, load;
  logic [NAXIS-1:0] step, at_end, sync_on, win_on;
  tval_t            cnt [NAXIS];
  tval_t            rel [NAXIS];
  logic             vis;

  assign h_new = '{total: h_total_i, size: h_size_i, offset: h_offset_i,
                   sync_a: h_sync_a_i, sync_b: h_sync_b_i};
  assign v_new = '{total: v_total_i, size: v_size_i, offset: v_offset_i,
                   sync_a: v_sync_a_i, sync_b: v_sync_b_i};

  // frame boundary: both axes at their last position
  assign load = !legal || (at_end[0] && at_end[1]);

  lcd_cfg_shadow u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .h_new (h_new),
    .v_new (v_new),
    .h_act (act[0]),
    .v_act (act[1]),
    .legal (legal)
  );

  assign step[0] = 1'b1;
  assign step[1] = at_end[0];

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    lcd_axis_counter #(.W(TW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!legal),
      .step   (step[a]),
      .total  (act[a].total),
      .cnt    (cnt[a]),
      .at_end (at_end[a])
    );
    lcd_axis_decode u_dec (
      .cnt     (cnt[a]),
      .cfg     (act[a]),
      .sync_on (sync_on[a]),
      .win_on  (win_on[a]),
      .rel     (rel[a])
    );
  end

  assign vis = legal && win_on[0] && win_on[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      de      <= 1'b0;
      pix_x   <= '0;
      pix_y   <= '0;
    end else begin
      hsync_n <= !(legal && sync_on[0]);
      vsync_n <= !(legal && sync_on[1]);
      de      <= vis;
      pix_x   <= vis ? rel[0] : '0;
      pix_y   <= vis ? rel[1] : '0;
    end
  end

  // R6: coordinates rest at zero outside the window
  p_xy_zero_off_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pix_x == '0 && pix_y == '0));

  // R8: an illegal working set yields an idle raster on the next clock
  p_idle_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> (!de && hsync_n && vsync_n));

  // R2: the line count holds unless the line ends
  p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && !at_end[0]) |=> $stable(cnt[1]));

  // R8: a held raster sits at the origin
  p_origin_when_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> (cnt[0] == '0 && cnt[1] == '0));
endmodule

// File: tb/lcd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] ht, hs, ho, h0, h1, vt, vs, vo, v0, v1;
  logic hsync_n, vsync_n, de;
  logic [11:0] pix_x, pix_y;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R9";
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_total_i(ht), .h_size_i(hs), .h_offset_i(ho), .h_sync_a_i(h0), .h_sync_b_i(h1),
    .v_total_i(vt), .v_size_i(vs), .v_offset_i(vo), .v_sync_a_i(v0), .v_sync_b_i(v1),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .pix_x(pix_x), .pix_y(pix_y)
  );

  // behavioural raster model
  int a_ht, a_hs, a_ho, a_h0, a_h1, a_vt, a_vs, a_vo, a_v0, a_v1;
  int hc, vc;
  logic e_hs_n = 1'b1, e_vs_n = 1'b1, e_de = 1'b0;
  int e_x = 0, e_y = 0;

  task automatic take_inputs();
    a_ht = ht; a_hs = hs; a_ho = ho; a_h0 = h0; a_h1 = h1;
    a_vt = vt; a_vs = vs; a_vo = vo; a_v0 = v0; a_v1 = v1;
  endtask

  always @(posedge clk) begin
    bit ok, hw, vw, frame_end;
    if (!rst_n) begin
      a_ht = 0; a_hs = 0; a_ho = 0; a_h0 = 0; a_h1 = 0;
      a_vt = 0; a_vs = 0; a_vo = 0; a_v0 = 0; a_v1 = 0;
      hc = 0; vc = 0;
      e_hs_n = 1'b1; e_vs_n = 1'b1; e_de = 1'b0; e_x = 0; e_y = 0;
    end else begin
      ok = (a_ho + a_hs < a_ht) && (a_vo + a_vs < a_vt);
      hw = hc >= a_ho && hc < a_ho + a_hs;
      vw = vc >= a_vo && vc < a_vo + a_vs;
      e_hs_n = !(ok && hc >= a_h0 && hc < a_h1);
      e_vs_n = !(ok && vc >= a_v0 && vc < a_v1);
      e_de = ok && hw && vw;
      e_x = e_de ? hc - a_ho : 0;
      e_y = e_de ? vc - a_vo : 0;
      if (!ok) begin
        hc = 0; vc = 0;
        take_inputs();
      end else begin
        frame_end = (hc == a_ht - 1) && (vc == a_vt - 1);
        if (hc == a_ht - 1) begin
          hc = 0;
          vc = (vc == a_vt - 1) ? 0 : vc + 1;
        end else begin
          hc = hc + 1;
        end
        if (frame_end) take_inputs();
      end
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s got %0d expected %0d at %0t", req, phase, what, got, exp, $time);
    end
  endtask

  // per-clock compare plus edge and activity bookkeeping
  int cyc = 0, h_last = 0, v_last = 0, h_period = 0, v_period = 0;
  int de_total = 0, hs_low_total = 0, vs_low_total = 0;
  logic prev_h = 1'b1, prev_v = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      chk("R3", "hsync_n", hsync_n, e_hs_n);   // R10 timing as well
      chk("R4", "vsync_n", vsync_n, e_vs_n);
      chk("R5", "de", de, e_de);
      chk("R6", "pix_x", pix_x, e_x);
      chk("R6", "pix_y", pix_y, e_y);
    end
    if (prev_h && !hsync_n) begin h_period = cyc - h_last; h_last = cyc; end
    if (prev_v && !vsync_n) begin v_period = cyc - v_last; v_last = cyc; end
    prev_h = hsync_n; prev_v = vsync_n;
    if (de) de_total++;
    if (!hsync_n) hs_low_total++;
    if (!vsync_n) vs_low_total++;
  end

  task automatic set_cfg(int t, int s, int o, int a, int b,
                         int tv, int sv, int ov, int av, int bv);
    @(negedge clk);
    ht = 12'(t); hs = 12'(s); ho = 12'(o); h0 = 12'(a); h1 = 12'(b);
    vt = 12'(tv); vs = 12'(sv); vo = 12'(ov); v0 = 12'(av); v1 = 12'(bv);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in phase %s", phase);
    summary();
    $finish;
  end

  initial begin
    int d0, hl0, vl0;
    set_cfg(20, 8, 6, 2, 4, 10, 5, 3, 1, 2);
    run(3);
    // R9: reset values
    chk("R9", "hsync_n", hsync_n, 1);
    chk("R9", "vsync_n", vsync_n, 1);
    chk("R9", "de", de, 0);
    chk("R9", "pix_x", pix_x, 0);
    chk("R9", "pix_y", pix_y, 0);
    rst_n = 1'b1;
    cmp_en = 1;

    phase = "R1";
    run(700);
    chk("R1", "hsync period", h_period, 20);
    chk("R2", "vsync period", v_period, 200);

    phase = "R7";                       // change mid-frame
    run(37);
    set_cfg(16, 10, 5, 1, 3, 8, 4, 2, 0, 1);
    run(600);
    chk("R7", "hsync period", h_period, 16);
    chk("R7", "vsync period", v_period, 128);

    phase = "R8";                       // offset+size == total
    set_cfg(16, 10, 6, 1, 3, 8, 4, 2, 0, 1);
    run(300);
    d0 = de_total; hl0 = hs_low_total; vl0 = vs_low_total;
    run(200);
    chk("R8", "de cycles", de_total - d0, 0);
    chk("R8", "hsync low cycles", hs_low_total - hl0, 0);
    chk("R8", "vsync low cycles", vs_low_total - vl0, 0);
    set_cfg(0, 0, 0, 0, 0, 8, 4, 2, 0, 1);  // zero total
    run(50);
    d0 = de_total; hl0 = hs_low_total;
    run(100);
    chk("R8", "de cycles zero total", de_total - d0, 0);
    chk("R8", "hsync low zero total", hs_low_total - hl0, 0);
    set_cfg(20, 8, 6, 2, 4, 10, 5, 3, 1, 2);  // recovery
    run(450);
    chk("R8", "hsync period after recovery", h_period, 20);

    phase = "R5";                       // no pulse, empty window
    set_cfg(12, 0, 4, 3, 3, 5, 2, 1, 0, 2);
    run(250);
    d0 = de_total; hl0 = hs_low_total;
    run(100);
    chk("R5", "de cycles with size 0", de_total - d0, 0);
    chk("R3", "hsync low with equal bounds", hs_low_total - hl0, 0);

    phase = "R1";                       // full 12-bit line
    set_cfg(4095, 4000, 90, 10, 50, 2, 1, 0, 1, 2);
    run(2 * 8190 + 200);
    chk("R1", "hsync period 4095", h_period, 4095);
    chk("R2", "vsync period 8190", v_period, 8190);

    summary();
    $finish;
  end
endmodule